// File: doc/BRIEF.md
# HDLC Receive FIFO Drain Controller

This block empties a 32-byte HDLC receive FIFO into a linear frame buffer. The FIFO signals two kinds of events: a pool-full event, meaning a whole FIFO block of 32 bytes is waiting, and a message-end event, meaning the tail of a frame is waiting. On message end the block also samples a byte-count value and a receive status byte. From these it decides whether to copy and deliver the frame or to throw it away.

Bytes are appended at a running write index, one byte per cycle, through a registered write port that suits a block RAM. After each block has been handled, the FIFO gets a one-cycle release strobe, which acknowledges the block and frees the FIFO space. When a message ends, the block gives either a deliver pulse with the frame length or a drop pulse. In both cases the write index then returns to zero, so the next frame starts at buffer address 0. The block has a second status mode. In that mode the status must also show a valid-frame bit, and one trailing status byte is removed from the length that is delivered.

Top module: `hdlc_rx_drain`

## Requirements
- R1: After synchronous reset, fifo_pop, fifo_release, buf_we, frame_deliver and frame_drop are low, and the first byte copied after reset is written to buffer address 0.
- R2: A pool-full event copies exactly 32 bytes. One byte is popped each cycle and written to consecutive buffer addresses that start at the current write index. The copy ends with one fifo_release pulse and no deliver or drop pulse.
- R3: On message end the block count is rx_count[4:0], and the value 0 means 32 bytes. Bits 7:5 of rx_count have no effect.
- R4: With variant_mode low, a message end is accepted only when rx_status bits 6 (overflow), 5 (CRC good) and 4 (aborted) equal 0,1,0. Bits 7 and 3:0 are ignored. A rejected frame pops nothing, pulses fifo_release and frame_drop together, and clears the write index.
- R5: With variant_mode high, acceptance also needs rx_status bit 7 (valid frame) set, so bits 7:4 must equal 1,0,1,0. The delivered length is the number of bytes copied for the frame minus one.
- R6: If the write index plus the block count is greater than or equal to MAX_LEN, nothing is copied, fifo_release pulses and the index returns to 0. On a message end this also gives a frame_drop pulse. On a pool-full event it gives no deliver or drop pulse.
- R7: On an accepted message end, frame_deliver, frame_len and fifo_release are presented in the cycle right after the cycle in which the last byte of the frame is on the write port.
- R8: A frame whose delivered length would be less than 1 gives frame_drop instead of frame_deliver.
- R9: After every message end, delivered or dropped, the write index is 0, so the next copied byte goes to address 0.
- R10: Events that arrive while a copy is running have no effect. If both events arrive in the same idle cycle, the message end is the one handled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pool_full_evt | input | 1 | One-cycle pulse: a full 32-byte FIFO block is ready |
| msg_end_evt | input | 1 | One-cycle pulse: the last block of a frame is ready |
| variant_mode | input | 1 | Selects the status mode that needs the valid bit and strips the trailing byte |
| rx_status | input | 8 | Receive status byte, sampled with msg_end_evt |
| rx_count | input | 8 | Byte-count value, sampled with msg_end_evt; low 5 bits used |
| fifo_data | input | 8 | Head byte of the receive FIFO |
| fifo_pop | output | 1 | Pops the FIFO head this cycle |
| fifo_release | output | 1 | One-cycle strobe that releases the FIFO block |
| buf_we | output | 1 | Frame buffer write enable |
| buf_addr | output | IDX_W | Frame buffer write address |
| buf_wdata | output | 8 | Frame buffer write data |
| frame_len | output | IDX_W | Length of the frame being delivered, valid with frame_deliver |
| frame_deliver | output | 1 | One-cycle pulse: a frame is ready in the buffer |
| frame_drop | output | 1 | One-cycle pulse: a frame has been discarded |

## Verification
A wrong write index shows at the ports within one cycle. It appears as a buffer address that breaks the consecutive sequence, as a first address after a message end that is not 0, or as the wrong length or the wrong boundary decision at the next message end. A wrong remaining-count or sequencer state shows as a pop count other than 32 or the decoded count before the release strobe. It also shows as a deliver pulse that does not follow the last write by exactly one cycle. Status decoding errors show on the same message end as a deliver where a drop was due, or the reverse. Each of these cases is driven with the status patterns at the acceptance edges and with block sizes that land on either side of the MAX_LEN limit.

// File: rtl/hdlc_rxd_pkg.sv
package hdlc_rxd_pkg;
  typedef enum logic [1:0] {
    DS_IDLE = 2'd0,
    DS_COPY = 2'd1,
    DS_FIN  = 2'd2
  } drain_st_e;

  // receive status bit positions, decoded by the acceptance check
  localparam logic [7:0] RS_VALID = 8'h80;
  localparam logic [7:0] RS_OVF   = 8'h40;
  localparam logic [7:0] RS_CRCOK = 8'h20;
  localparam logic [7:0] RS_ABORT = 8'h10;
endpackage

// File: rtl/hdlc_rxd_judge.sv
module hdlc_rxd_judge #(
  parameter int FIFO_BYTES = 32,
  parameter int CNT_W      = $clog2(FIFO_BYTES)
) (
  input  logic             variant,
  input  logic [7:0]       status,
  input  logic [CNT_W-1:0] count,
  output logic             accept,
  output logic [CNT_W:0]   blk_len
);
  import hdlc_rxd_pkg::*;

  localparam logic [CNT_W:0] FULL_BLK = (CNT_W+1)'(FIFO_BYTES);

  logic [7:0] chk_mask;
  logic [7:0] chk_want;

  always_comb begin
    if (variant) begin
      chk_mask = RS_VALID | RS_OVF | RS_CRCOK | RS_ABORT;
      chk_want = RS_VALID | RS_CRCOK;
    end else begin
      chk_mask = RS_OVF | RS_CRCOK | RS_ABORT;
      chk_want = RS_CRCOK;
    end
    accept = ((status & chk_mask) == chk_want);
  end

  // a zero count stands for a completely full FIFO block
  assign blk_len = (count == '0) ? FULL_BLK : {1'b0, count};
endmodule

// File: rtl/hdlc_rxd_index.sv
module hdlc_rxd_index #(
  parameter int MAX_LEN = 300,
  parameter int IDX_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W:0]   blk_len,
  output logic [IDX_W-1:0] idx,
  output logic             overrun
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(MAX_LEN);

  logic [IDX_W:0] sum;

  assign sum     = {1'b0, idx} + (IDX_W+1)'(blk_len);
  assign overrun = (sum >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx <= '0;
    end else if (inc) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rxd_seq.sv
module hdlc_rxd_seq #(
  parameter int IDX_W  = 9,
  parameter int CNT_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pool_evt,
  input  logic              end_evt,
  input  logic              variant,
  input  logic              accept,
  input  logic              overrun,
  input  logic [CNT_W:0]    blk_len,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              idx_clr,
  output logic              idx_inc,
  output logic              fifo_pop,
  output logic              fifo_release,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic [IDX_W-1:0]  frame_len,
  output logic              frame_deliver,
  output logic              frame_drop
);
  import hdlc_rxd_pkg::*;

  drain_st_e         state;
  logic [CNT_W:0]    remain;
  logic              is_end;
  logic              strip;
  logic [IDX_W-1:0]  fin_len;

  assign fin_len  = idx - {{(IDX_W-1){1'b0}}, strip};
  assign fifo_pop = (state == DS_COPY);
  assign idx_inc  = (state == DS_COPY);

  always_comb begin
    idx_clr = 1'b0;
    case (state)
      DS_IDLE: begin
        if (end_evt)       idx_clr = !accept || overrun;
        else if (pool_evt) idx_clr = overrun;
      end
      DS_FIN:  idx_clr = is_end;
      default: idx_clr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= DS_IDLE;
      remain        <= '0;
      is_end        <= 1'b0;
      strip         <= 1'b0;
      buf_we        <= 1'b0;
      buf_addr      <= '0;
      buf_wdata     <= '0;
      fifo_release  <= 1'b0;
      frame_deliver <= 1'b0;
      frame_drop    <= 1'b0;
      frame_len     <= '0;
    end else begin
      buf_we        <= 1'b0;
      fifo_release  <= 1'b0;
      frame_deliver <= 1'b0;
      frame_drop    <= 1'b0;
      case (state)
        DS_IDLE: begin
          if (end_evt) begin
            strip <= variant;
            if (!accept || overrun) begin
              fifo_release <= 1'b1;
              frame_drop   <= 1'b1;
            end else begin
              remain <= blk_len;
              is_end <= 1'b1;
              state  <= DS_COPY;
            end
          end else if (pool_evt) begin
            if (overrun) begin
              fifo_release <= 1'b1;
            end else begin
              remain <= blk_len;
              is_end <= 1'b0;
              state  <= DS_COPY;
            end
          end
        end
        DS_COPY: begin
          buf_we    <= 1'b1;
          buf_addr  <= idx;
          buf_wdata <= fifo_data;
          remain    <= remain - 1'b1;
          if (remain == (CNT_W+1)'(1)) state <= DS_FIN;
        end
        DS_FIN: begin
          fifo_release <= 1'b1;
          if (is_end) begin
            if (fin_len != '0) begin
              frame_deliver <= 1'b1;
              frame_len     <= fin_len;
            end else begin
              frame_drop <= 1'b1;
            end
          end
          state <= DS_IDLE;
        end
        default: state <= DS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_rx_drain.sv
module hdlc_rx_drain #(
  parameter int DATA_W     = 8,
  parameter int FIFO_BYTES = 32,
  parameter int MAX_LEN    = 300,
  localparam int CNT_W     = $clog2(FIFO_BYTES),
  localparam int IDX_W     = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pool_full_evt,
  input  logic              msg_end_evt,
  input  logic              variant_mode,
  input  logic [7:0]        rx_status,
  input  logic [7:0]        rx_count,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              fifo_release,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic [IDX_W-1:0]  frame_len,
  output logic              frame_deliver,
  output logic              frame_drop
);
  localparam logic [CNT_W:0] FULL_BLK = (CNT_W+1)'(FIFO_BYTES);

  logic             accept;
  logic [CNT_W:0]   end_len;
  logic [CNT_W:0]   sel_len;
  logic [IDX_W-1:0] wr_idx;
  logic             overrun;
  logic             idx_clr;
  logic             idx_inc;
  logic             unused_cnt_hi;

  assign unused_cnt_hi = ^rx_count[7:CNT_W];
  assign sel_len       = msg_end_evt ? end_len : FULL_BLK;

  hdlc_rxd_judge #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) u_judge (
    .variant (variant_mode),
    .status  (rx_status),
    .count   (rx_count[CNT_W-1:0]),
    .accept  (accept),
    .blk_len (end_len)
  );

  hdlc_rxd_index #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_index (
    .clk     (clk),
    .rst     (rst),
    .clr     (idx_clr),
    .inc     (idx_inc),
    .blk_len (sel_len),
    .idx     (wr_idx),
    .overrun (overrun)
  );

  hdlc_rxd_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .pool_evt      (pool_full_evt),
    .end_evt       (msg_end_evt),
    .variant       (variant_mode),
    .accept        (accept),
    .overrun       (overrun),
    .blk_len       (sel_len),
    .idx           (wr_idx),
    .fifo_data     (fifo_data),
    .idx_clr       (idx_clr),
    .idx_inc       (idx_inc),
    .fifo_pop      (fifo_pop),
    .fifo_release  (fifo_release),
    .buf_we        (buf_we),
    .buf_addr      (buf_addr),
    .buf_wdata     (buf_wdata),
    .frame_len     (frame_len),
    .frame_deliver (frame_deliver),
    .frame_drop    (frame_drop)
  );
endmodule

// File: rtl/hdlc_rx_drain_chk.sv
module hdlc_rx_drain_chk #(
  parameter int MAX_LEN = 300,
  parameter int IDX_W   = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_pop,
  input logic             fifo_release,
  input logic             buf_we,
  input logic [IDX_W-1:0] buf_addr,
  input logic [IDX_W-1:0] frame_len,
  input logic             frame_deliver,
  input logic             frame_drop,
  input logic [IDX_W-1:0] wr_idx
);
  localparam logic [IDX_W-1:0] LAST_ADDR = IDX_W'(MAX_LEN - 1);

  a_r2_pop_not_release: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_release);

  a_r2_write_after_pop: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(fifo_pop));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(buf_we)) |-> (buf_addr == $past(buf_addr) + 1'b1));

  a_r6_addr_bound: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (buf_addr <= LAST_ADDR));

  a_r7_deliver_after_write: assert property (@(posedge clk) disable iff (rst)
    frame_deliver |-> $past(buf_we));

  a_r7_outcome_releases: assert property (@(posedge clk) disable iff (rst)
    (frame_deliver || frame_drop) |-> fifo_release);

  a_r8_deliver_nonzero: assert property (@(posedge clk) disable iff (rst)
    frame_deliver |-> (frame_len != '0 && !frame_drop));

  a_r9_index_cleared: assert property (@(posedge clk) disable iff (rst)
    (frame_deliver || frame_drop) |-> (wr_idx == '0));
endmodule

bind hdlc_rx_drain hdlc_rx_drain_chk #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fifo_pop      (fifo_pop),
  .fifo_release  (fifo_release),
  .buf_we        (buf_we),
  .buf_addr      (buf_addr),
  .frame_len     (frame_len),
  .frame_deliver (frame_deliver),
  .frame_drop    (frame_drop),
  .wr_idx        (wr_idx)
);

// File: tb/tb_hdlc_rx_drain.sv
`timescale 1ns/1ps
module tb_hdlc_rx_drain;
  localparam int MAXL = 300;
  localparam int IW   = $clog2(MAXL + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pool_full_evt = 1'b0, msg_end_evt = 1'b0, variant_mode = 1'b0;
  logic [7:0] rx_status = '0, rx_count = '0, fifo_data;
  logic fifo_pop, fifo_release, buf_we, frame_deliver, frame_drop;
  logic [IW-1:0] buf_addr, frame_len;
  logic [7:0] buf_wdata;

  always #2 clk = ~clk;

  hdlc_rx_drain #(.MAX_LEN(MAXL)) dut (
    .clk(clk), .rst(rst), .pool_full_evt(pool_full_evt), .msg_end_evt(msg_end_evt),
    .variant_mode(variant_mode), .rx_status(rx_status), .rx_count(rx_count),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .fifo_release(fifo_release),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .frame_len(frame_len), .frame_deliver(frame_deliver), .frame_drop(frame_drop));

  int n_tests = 0, n_fail = 0;
  int model_idx = 0;
  int exp_wr_addr = 0;
  int wr_bad = 0;
  int wr_n = 0;
  bit done = 0;
  logic [15:0] pop_n;

  // FIFO model: byte k of the stream is k ^ 0x5A
  assign fifo_data = pop_n[7:0] ^ 8'h5A;
  always @(posedge clk) begin
    if (rst) pop_n <= '0;
    else if (fifo_pop) pop_n <= pop_n + 16'd1;
  end

  // buffer write monitor
  always @(negedge clk) begin
    if (!rst && buf_we) begin
      if (int'(buf_addr) != exp_wr_addr || buf_wdata != (8'(wr_n) ^ 8'h5A)) wr_bad++;
      exp_wr_addr++;
      wr_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit ev_end, input bit ev_pool, input bit vm,
                        input logic [7:0] st, input logic [7:0] cn,
                        input int e_pops, input bit e_dlv, input bit e_drp,
                        input int e_len, input bit inject, input string tg);
    int pops = 0, nd = 0, np = 0, got_len = -1, bad0;
    bit seen_rel = 0, prev_we = 0, after_ok = 1;
    exp_wr_addr = model_idx;
    bad0 = wr_bad;
    @(negedge clk);
    pool_full_evt = ev_pool; msg_end_evt = ev_end; variant_mode = vm;
    rx_status = st; rx_count = cn;
    for (int c = 0; c < 80 && !seen_rel; c++) begin
      @(negedge clk);
      pool_full_evt = 1'b0;
      msg_end_evt = (inject && c == 3);
      if (fifo_pop) pops++;
      if (frame_deliver) begin
        nd++; got_len = int'(frame_len);
        if (!prev_we) after_ok = 0;
      end
      if (frame_drop) np++;
      if (fifo_release) seen_rel = 1;
      prev_we = buf_we;
    end
    msg_end_evt = 1'b0;
    chk(seen_rel, tg, "release strobe seen", int'(seen_rel), 1);
    chk(pops == e_pops, tg, "bytes popped", pops, e_pops);
    chk(nd == int'(e_dlv), tg, "deliver pulses", nd, int'(e_dlv));
    chk(np == int'(e_drp), tg, "drop pulses", np, int'(e_drp));
    chk(wr_bad == bad0, "R2,R9", "write address/data mismatches", wr_bad - bad0, 0);
    if (e_dlv) begin
      chk(got_len == e_len, tg, "frame length", got_len, e_len);
      chk(after_ok, "R7", "deliver one cycle after last write", int'(after_ok), 1);
    end
    if (ev_end) model_idx = 0;
    else model_idx = (e_pops == 0) ? 0 : model_idx + e_pops;
  endtask

  typedef struct packed {
    logic       is_end;
    logic       vm;
    logic [7:0] st;
    logic [7:0] cn;
    logic [6:0] pops;
    logic       dlv;
    logic       drp;
    logic [8:0] len;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'h20, 8'h05, 7'd5,  1'b1, 1'b0, 9'd5},
    '{1'b0, 1'b0, 8'h00, 8'h00, 7'd32, 1'b0, 1'b0, 9'd0},
    '{1'b1, 1'b0, 8'h20, 8'h00, 7'd32, 1'b1, 1'b0, 9'd64},
    '{1'b1, 1'b0, 8'h60, 8'h04, 7'd0,  1'b0, 1'b1, 9'd0},
    '{1'b1, 1'b0, 8'h30, 8'h04, 7'd0,  1'b0, 1'b1, 9'd0},
    '{1'b1, 1'b0, 8'h00, 8'h04, 7'd0,  1'b0, 1'b1, 9'd0},
    '{1'b1, 1'b1, 8'hA0, 8'h03, 7'd3,  1'b1, 1'b0, 9'd2},
    '{1'b1, 1'b1, 8'h20, 8'h03, 7'd0,  1'b0, 1'b1, 9'd0},
    '{1'b1, 1'b1, 8'hA0, 8'h01, 7'd1,  1'b0, 1'b1, 9'd0},
    '{1'b1, 1'b0, 8'h2F, 8'hE3, 7'd3,  1'b1, 1'b0, 9'd3},
    '{1'b1, 1'b1, 8'hE0, 8'h02, 7'd0,  1'b0, 1'b1, 9'd0},
    '{1'b1, 1'b0, 8'hA0, 8'h02, 7'd2,  1'b1, 1'b0, 9'd2}
  };
  localparam string VTAG [NV] = '{"R3", "R2", "R3", "R4", "R4", "R4",
                                  "R5", "R5", "R8", "R3", "R5", "R4"};

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!fifo_pop, "R1", "fifo_pop after reset", int'(fifo_pop), 0);
    chk(!fifo_release, "R1", "fifo_release after reset", int'(fifo_release), 0);
    chk(!buf_we, "R1", "buf_we after reset", int'(buf_we), 0);
    chk(!frame_deliver, "R1", "frame_deliver after reset", int'(frame_deliver), 0);
    chk(!frame_drop, "R1", "frame_drop after reset", int'(frame_drop), 0);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].is_end, !VECS[i].is_end, VECS[i].vm, VECS[i].st, VECS[i].cn,
             int'(VECS[i].pops), VECS[i].dlv, VECS[i].drp, int'(VECS[i].len),
             1'b0, VTAG[i]);
    end

    // R10: message end during a pool copy is ignored
    run_op(1'b0, 1'b1, 1'b0, 8'h20, 8'h02, 32, 1'b0, 1'b0, 0, 1'b1, "R10");
    // R10: both events together, message end is handled (index continues from 32)
    run_op(1'b1, 1'b1, 1'b0, 8'h20, 8'h02, 2, 1'b1, 1'b0, 34, 1'b0, "R10");

    // R6: pool-full overrun at index 288
    for (int k = 0; k < 9; k++) run_op(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 32, 1'b0, 1'b0, 0, 1'b0, "R2");
    run_op(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 0, 1'b0, 1'b0, 0, 1'b0, "R6");
    // R9: after the overrun the index is 0 again
    run_op(1'b1, 1'b0, 1'b0, 8'h20, 8'h04, 4, 1'b1, 1'b0, 4, 1'b0, "R9");

    // R6: message end reaching exactly MAX_LEN is dropped
    for (int k = 0; k < 9; k++) run_op(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 32, 1'b0, 1'b0, 0, 1'b0, "R2");
    run_op(1'b1, 1'b0, 1'b0, 8'h20, 8'h0C, 0, 1'b0, 1'b1, 0, 1'b0, "R6");
    // R6: one byte below the limit is delivered
    for (int k = 0; k < 9; k++) run_op(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 32, 1'b0, 1'b0, 0, 1'b0, "R2");
    run_op(1'b1, 1'b0, 1'b0, 8'h20, 8'h0B, 11, 1'b1, 1'b0, 299, 1'b0, "R6");
    // R9: next frame starts at address 0
    run_op(1'b1, 1'b0, 1'b0, 8'h20, 8'h01, 1, 1'b1, 1'b0, 1, 1'b0, "R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule